// File: doc/BRIEF.md
# Two-Channel Serial Interrupt Arbiter

This block decides which interrupt request of a two-channel serial controller reaches the processor, and in what order. Every channel raises receive, transmit and external/status requests as one-cycle pulses. A special receive condition is also a pulse. Together the two channels use six pending levels in a fixed ranking, and every channel A level ranks above every channel B level. The master control register decides whether requests are accepted at all, whether the returned vector carries status, and whether the downstream daisy chain is shut off.

The processor acknowledges with a strobe. The strobe captures the vector for the winning level and moves that level from pending to under service, which blocks it and every lower level. A reset-highest command clears the top level that is either pending or under service. The interrupt output is active low. The daisy-chain output passes the enable on to lower devices only while this block has nothing pending and nothing under service.

Top module: `sio_irq_prio`

## Requirements
- R1: A request pulse is accepted only while the master-enable bit (master control bit 3) is 1. A request that arrives while the bit is 0 is dropped and leaves `pend` unchanged.
- R2: `pend` bits 5, 4 and 3 are channel A receive, transmit and external/status. Bits 2, 1 and 0 are the same three for channel B. Bits 7:6 read 0, and all bits are 0 after reset.
- R3: An acknowledge serves the highest eligible level, in the order A-receive, A-transmit, A-external, B-receive, B-transmit, B-external.
- R4: When the status-in-vector bit (master control bit 0) is 1, the captured vector takes bits 7:4 and bit 0 from `base_vec`. Bits 3:1 hold {channel-is-A, source}, where source is 0 for transmit, 1 for external, 2 for receive and 3 for special receive.
- R5: When the status-in-vector bit is 0, the captured vector equals `base_vec`.
- R6: `int_n` is 0 exactly when an eligible level is pending, master enable is 1 and `iei` is 1. A level is eligible when neither it nor any higher level is under service.
- R7: An acknowledge clears the pending bit of the served level and puts that level under service. `ieo` is 0 while any level is pending or under service.
- R8: The disable-lower-chain bit (master control bit 2) holds `ieo` at 0 even with no level pending. It does not affect `int_n`.
- R9: A reset-highest pulse clears the pending and under-service state of the highest level that has either one set. Lower levels are unchanged.
- R10: A special receive request sets the external/status level of its channel and reports source 3 in the vector.
- R11: While `iei` is 0, `int_n` is 1 and an acknowledge changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mctl_we | input | 1 | Write strobe for the master control register |
| mctl_wdata | input | 8 | Master control data: bit 3 enable, bit 2 disable lower chain, bit 0 status in vector |
| base_vec | input | 8 | Base interrupt vector |
| rx_req | input | 2 | Receive request pulses (bit 1 = channel A, bit 0 = channel B) |
| tx_req | input | 2 | Transmit request pulses |
| ext_req | input | 2 | External/status request pulses |
| spc_req | input | 2 | Special receive condition pulses |
| iei | input | 1 | Daisy-chain enable in |
| ack | input | 1 | Interrupt acknowledge strobe |
| rst_hi | input | 1 | Reset-highest command pulse |
| int_n | output | 1 | Interrupt request, active low |
| ieo | output | 1 | Daisy-chain enable out |
| vec_out | output | 8 | Vector captured at the last effective acknowledge |
| pend | output | 8 | Pending-status register |

## Verification
Some rules can be checked on every cycle, and the assertions cover them. No pending bit appears while master enable is off. A low `int_n` always has a pending level behind it. The chain output stays low under disable-lower-chain or a low `iei`. An effective acknowledge adds exactly one under-service level, and a lone reset-highest removes exactly one level. Other behaviour needs the bench's scenarios: the full six-level service order, the exact vector bits for each channel and source, the blocking of lower levels while a higher one is under service, and an acknowledge that is ignored while `iei` is low.

// File: rtl/sio_irq_prio.sv
module sio_irq_prio #(
  parameter int VW       = 8,
  parameter int CODE_LSB = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mctl_we,
  input  logic [7:0]    mctl_wdata,
  input  logic [VW-1:0] base_vec,
  input  logic [1:0]    rx_req,
  input  logic [1:0]    tx_req,
  input  logic [1:0]    ext_req,
  input  logic [1:0]    spc_req,
  input  logic          iei,
  input  logic          ack,
  input  logic          rst_hi,
  output logic          int_n,
  output logic          ieo,
  output logic [VW-1:0] vec_out,
  output logic [7:0]    pend
);
  localparam int NLV = 6;

  logic           mie, dlc, vis;
  logic [NLV-1:0] ip, ius, ip_nx, ius_nx, set_lv;
  logic [1:0]     spc_q;
  logic           win_ok, top_ok, blk;
  logic [2:0]     win, top;
  logic [1:0]     src;
  logic [VW-1:0]  vec_w;

  assign set_lv = {rx_req[1], tx_req[1], ext_req[1] | spc_req[1],
                   rx_req[0], tx_req[0], ext_req[0] | spc_req[0]} & {NLV{mie}};

  always_comb begin
    blk = 1'b0; win_ok = 1'b0; win = '0;
    top_ok = 1'b0; top = '0;
    for (int i = NLV-1; i >= 0; i--) begin
      if (ius[i]) blk = 1'b1;
      if (!blk && ip[i] && !win_ok) begin
        win_ok = 1'b1; win = 3'(i);
      end
      if ((ip[i] || ius[i]) && !top_ok) begin
        top_ok = 1'b1; top = 3'(i);
      end
    end
  end

  always_comb begin
    case (win)
      3'd5, 3'd2: src = 2'd2;
      3'd4, 3'd1: src = 2'd0;
      3'd3:       src = spc_q[1] ? 2'd3 : 2'd1;
      default:    src = spc_q[0] ? 2'd3 : 2'd1;
    endcase
    vec_w = base_vec;
    if (vis) vec_w[CODE_LSB +: 3] = {(win >= 3'd3), src};
  end

  always_comb begin
    ip_nx  = ip;
    ius_nx = ius;
    if (rst_hi && top_ok) begin
      ip_nx[top]  = 1'b0;
      ius_nx[top] = 1'b0;
    end
    if (ack && iei && win_ok) begin
      ip_nx[win]  = 1'b0;
      ius_nx[win] = 1'b1;
    end
    ip_nx = ip_nx | set_lv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mie <= 1'b0; dlc <= 1'b0; vis <= 1'b0;
      ip <= '0; ius <= '0; spc_q <= '0; vec_out <= '0;
    end else begin
      if (mctl_we) begin
        mie <= mctl_wdata[3];
        dlc <= mctl_wdata[2];
        vis <= mctl_wdata[0];
      end
      ip  <= ip_nx;
      ius <= ius_nx;
      if (set_lv[3]) spc_q[1] <= spc_req[1];
      if (set_lv[0]) spc_q[0] <= spc_req[0];
      if (ack && iei && win_ok) vec_out <= vec_w;
    end
  end

  assign int_n = ~(win_ok & mie & iei);
  assign ieo   = iei & ~dlc & ~(|ius) & ~(|ip);
  assign pend  = {2'b00, ip};

  AST_NO_SET_WITHOUT_MIE: assert property (@(posedge clk) disable iff (!rst_n)
    !mie |=> (ip & ~$past(ip)) == '0); // R1
  AST_INT_HAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    !int_n |-> (pend != 8'd0 && iei)); // R6
  AST_ACK_TAKES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && iei && !int_n && !rst_hi) |=> $countones(ius) == $past($countones(ius)) + 1); // R7
  AST_DLC_IEO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (dlc || !iei) |-> !ieo); // R8
  AST_RST_HI_ONE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_hi && !ack && (rx_req | tx_req | ext_req | spc_req) == 2'b00 && (ip | ius) != '0)
    |=> $countones(ip | ius) + 1 == $past($countones(ip | ius))); // R9
  AST_IEI_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !iei |-> int_n); // R11
endmodule

// File: tb/sio_irq_prio_tb.sv
module sio_irq_prio_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mctl_we = 1'b0;
  logic [7:0] mctl_wdata = '0, base_vec = 8'hE1;
  logic [1:0] rx_req = '0, tx_req = '0, ext_req = '0, spc_req = '0;
  logic iei = 1'b1, ack = 1'b0, rst_hi = 1'b0;
  logic int_n, ieo;
  logic [7:0] vec_out, pend;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  sio_irq_prio u_dut (.clk, .rst_n, .mctl_we, .mctl_wdata, .base_vec, .rx_req, .tx_req,
    .ext_req, .spc_req, .iei, .ack, .rst_hi, .int_n, .ieo, .vec_out, .pend);

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr_ctl(logic [7:0] d);
    @(negedge clk); mctl_we = 1'b1; mctl_wdata = d;
    @(negedge clk); mctl_we = 1'b0;
  endtask

  task automatic pulse(logic [1:0] rx, logic [1:0] tx, logic [1:0] ex, logic [1:0] sp);
    @(negedge clk); rx_req = rx; tx_req = tx; ext_req = ex; spc_req = sp;
    @(negedge clk); rx_req = '0; tx_req = '0; ext_req = '0; spc_req = '0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic do_rst_hi();
    @(negedge clk); rst_hi = 1'b1;
    @(negedge clk); rst_hi = 1'b0;
  endtask

  task automatic t_reset();
    chk("R2 reset pend", pend, 8'h00);
    chk("R6 reset int_n", {7'd0, int_n}, 8'h01);
    chk("R7 reset ieo", {7'd0, ieo}, 8'h01);
    chk("R2 reset vec", vec_out, 8'h00);
  endtask

  task automatic t_mie_off();
    pulse(2'b11, 2'b11, 2'b11, 2'b00);
    chk("R1 dropped without enable", pend, 8'h00);
  endtask

  task automatic t_single();
    wr_ctl(8'h09);
    pulse(2'b00, 2'b01, 2'b00, 2'b00);
    chk("R2 B-tx bit", pend, 8'h02);
    chk("R6 int asserted", {7'd0, int_n}, 8'h00);
    do_ack();
    chk("R4 B-tx vector", vec_out, 8'hE1);
    chk("R7 pending cleared by ack", pend, 8'h00);
    chk("R7 ieo low under service", {7'd0, ieo}, 8'h00);
    do_rst_hi();
    chk("R9 ieo back high", {7'd0, ieo}, 8'h01);
  endtask

  task automatic t_priority();
    pulse(2'b11, 2'b11, 2'b11, 2'b00);
    chk("R2 all six", pend, 8'h3F);
    do_ack();
    chk("R3 A-rx first", vec_out, 8'hED);
    chk("R6 lower levels blocked", {7'd0, int_n}, 8'h01);
    do_rst_hi();
    chk("R6 int after release", {7'd0, int_n}, 8'h00);
    do_ack();
    chk("R3 A-tx second", vec_out, 8'hE9);
    do_rst_hi(); do_ack();
    chk("R3 A-ext third", vec_out, 8'hEB);
    do_rst_hi(); do_ack();
    chk("R3 B-rx fourth", vec_out, 8'hE5);
    chk("R7 two left", pend, 8'h03);
    do_rst_hi();
    chk("R9 clears under-service level only", pend, 8'h03);
    do_rst_hi(); do_rst_hi();
    chk("R9 all cleared", pend, 8'h00);
  endtask

  task automatic t_special();
    pulse(2'b00, 2'b00, 2'b00, 2'b01);
    chk("R10 special on B-ext level", pend, 8'h01);
    do_ack();
    chk("R10 special source code", vec_out, 8'hE7);
    do_rst_hi();
    pulse(2'b00, 2'b00, 2'b00, 2'b10);
    do_ack();
    chk("R10 A special code", vec_out, 8'hEF);
    do_rst_hi();
  endtask

  task automatic t_novis();
    wr_ctl(8'h08);
    base_vec = 8'h5A;
    pulse(2'b10, 2'b00, 2'b00, 2'b00);
    do_ack();
    chk("R5 unmodified vector", vec_out, 8'h5A);
    do_rst_hi();
    base_vec = 8'hE1;
  endtask

  task automatic t_dlc();
    wr_ctl(8'h0C);
    chk("R8 ieo forced low", {7'd0, ieo}, 8'h00);
    pulse(2'b00, 2'b01, 2'b00, 2'b00);
    chk("R8 int unaffected", {7'd0, int_n}, 8'h00);
    do_ack(); do_rst_hi();
    wr_ctl(8'h09);
    chk("R8 ieo released", {7'd0, ieo}, 8'h01);
  endtask

  task automatic t_iei_low();
    pulse(2'b00, 2'b10, 2'b00, 2'b00);
    iei = 1'b0;
    @(negedge clk);
    chk("R11 int held off", {7'd0, int_n}, 8'h01);
    do_ack();
    chk("R11 ack ignored", pend, 8'h10);
    iei = 1'b1;
    @(negedge clk);
    chk("R6 int with iei", {7'd0, int_n}, 8'h00);
    do_rst_hi();
    chk("R9 pending cleared", pend, 8'h00);
  endtask

  task automatic t_rst_pending();
    pulse(2'b01, 2'b00, 2'b01, 2'b00);
    chk("R2 B-rx and B-ext", pend, 8'h05);
    do_rst_hi();
    chk("R9 top pending cleared", pend, 8'h01);
    do_rst_hi();
    chk("R9 last cleared", pend, 8'h00);
  endtask

  task automatic t_mie_clear_gate();
    pulse(2'b00, 2'b00, 2'b01, 2'b00);
    wr_ctl(8'h01);
    chk("R6 no int without enable", {7'd0, int_n}, 8'h01);
    pulse(2'b10, 2'b00, 2'b00, 2'b00);
    chk("R1 later request dropped", pend, 8'h01);
    wr_ctl(8'h09);
    do_rst_hi();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mie_off();
    t_single();
    t_priority();
    t_special();
    t_novis();
    t_dlc();
    t_iei_low();
    t_rst_pending();
    t_mie_clear_gate();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule